// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Interrupt Channel

This block is an auxiliary timer channel whose external pin can serve as an interrupt input. When its 3-bit mode field selects capture operation, a chosen transition on the pin does two things in the same cycle. It copies the value of a free-running core timer into a 16-bit auxiliary register. It also sets a sticky request flag. When the channel's interrupt enable is set, that flag drives a request output towards the interrupt controller.

The pin is asynchronous to the block. It passes through a synchronizer chain, and a transition is detected by comparing the synchronized level with its sample from the previous cycle. A 3-bit edge code picks rising, falling or both edges, or no edge. Only its two low bits matter. Software can write the auxiliary register and clear the flag. A capture takes priority over either write when both fall in the same cycle.

Top module: `capt_irq_chan`

## Requirements
- R1: After reset, `aux_q` is 0, `req_flag` is 0 and `irq_out` is 0.
- R2: Triggers occur only while `mode` equals 3'b101. With any other mode value, pin transitions change neither `aux_q` nor `req_flag`.
- R3: When `edge_sel[1:0]` is 2'b01, a rising pin transition is a trigger and a falling one is not. `edge_sel[2]` has no effect.
- R4: When `edge_sel[1:0]` is 2'b10, a falling pin transition is a trigger and a rising one is not.
- R5: When `edge_sel[1:0]` is 2'b11, both rising and falling transitions are triggers.
- R6: When `edge_sel[1:0]` is 2'b00, no transition is a trigger.
- R7: A trigger loads `core_tmr` into `aux_q`. With the default two synchronizer stages, the new value appears after the third rising clock edge following the pin change, and it is the `core_tmr` value present just before that edge.
- R8: A trigger sets `req_flag`. The flag stays set until `flag_clr` is sampled high in a cycle without a trigger.
- R9: `irq_out` is high exactly when `req_flag` is high and `irq_en` is high.
- R10: If `flag_clr` coincides with a trigger, `req_flag` is set after that edge.
- R11: `aux_wr_en` loads `aux_wr_data` into `aux_q` at the next edge. If a trigger occurs in the same cycle, the captured `core_tmr` value is loaded instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous external capture/interrupt pin |
| mode | input | 3 | Timer mode field; 3'b101 selects capture |
| edge_sel | input | 3 | Edge code; bit 2 ignored, [1:0]: 00 none, 01 rise, 10 fall, 11 both |
| irq_en | input | 1 | Interrupt enable |
| aux_wr_en | input | 1 | Software write strobe for the auxiliary register |
| aux_wr_data | input | 16 | Software write data |
| flag_clr | input | 1 | Software clear strobe for the request flag |
| core_tmr | input | 16 | Running core timer value |
| aux_q | output | 16 | Auxiliary register contents |
| req_flag | output | 1 | Sticky request flag |
| irq_out | output | 1 | Interrupt/service request |

## Verification
A pin change is latched by the first synchronizer flop at the next rising edge and reaches the second flop at the edge after that. The edge detector then flags the transition in that same cycle, so `aux_q` and `req_flag` change at the third rising edge after the pin moves. `irq_out` follows the flag in the same cycle, since it is combinational. The bench drives inputs on falling edges and samples three falling edges after each pin change, holding `core_tmr` steady over that window so the expected capture value is unambiguous. For the priority cases, the clear and write strobes are applied on the falling edge just before the third rising edge, which places them in the trigger cycle.

// File: rtl/capt_pkg.sv
package capt_pkg;
    localparam logic [2:0] MODE_CAPTURE = 3'b101;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;
endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/capt_edge.sv
module capt_edge
    import capt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [1:0] code,
    input  logic       arm,
    output logic       trig
);
    logic prev_d, prev_q;
    logic rise, fall, hit;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
        unique case (edge_code_e'(code))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        trig = arm & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R6
    no_code_zero_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 2'b00) |-> !trig);
    // R2
    no_trig_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> !trig);
endmodule

// File: rtl/capt_irq_chan.sv
module capt_irq_chan
    import capt_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic [2:0]    mode,
    input  logic [2:0]    edge_sel,
    input  logic          irq_en,
    input  logic          aux_wr_en,
    input  logic [TW-1:0] aux_wr_data,
    input  logic          flag_clr,
    input  logic [TW-1:0] core_tmr,
    output logic [TW-1:0] aux_q,
    output logic          req_flag,
    output logic          irq_out
);
    typedef struct packed {
        logic [TW-1:0] aux;
        logic          flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     pin_sync;
    logic     capt_arm;
    logic     trig;

    capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign capt_arm = (mode == MODE_CAPTURE);

    capt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_sync),
        .code  (edge_sel[1:0]),
        .arm   (capt_arm),
        .trig  (trig)
    );

    always_comb begin
        st_d = st_q;
        if (aux_wr_en) st_d.aux  = aux_wr_data;
        if (flag_clr)  st_d.flag = 1'b0;
        if (trig) begin
            st_d.aux  = core_tmr;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aux_q    = st_q.aux;
    assign req_flag = st_q.flag;
    assign irq_out  = st_q.flag & irq_en;

    // R7
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (aux_q == $past(core_tmr)));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> req_flag);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && !flag_clr) |=> req_flag);
    // R2
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !aux_wr_en) |=> $stable(aux_q));
endmodule

// File: tb/capt_irq_chan_bench.sv
module capt_irq_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [2:0]  edge_sel = 3'b000;
    logic        irq_en = 1'b0;
    logic        aux_wr_en = 1'b0;
    logic [15:0] aux_wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] core_tmr = '0;
    logic [15:0] aux_q;
    logic        req_flag;
    logic        irq_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    capt_irq_chan u_capt_irq_chan (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode),
        .edge_sel(edge_sel), .irq_en(irq_en), .aux_wr_en(aux_wr_en),
        .aux_wr_data(aux_wr_data), .flag_clr(flag_clr), .core_tmr(core_tmr),
        .aux_q(aux_q), .req_flag(req_flag), .irq_out(irq_out)
    );

    // {mode, edge_sel, new pin level, trigger expected}
    localparam logic [7:0] VEC [NVEC] = '{
        {3'b101, 3'b001, 1'b1, 1'b1},   // R3 rise
        {3'b101, 3'b001, 1'b0, 1'b0},   // R3 fall ignored
        {3'b101, 3'b010, 1'b1, 1'b0},   // R4 rise ignored
        {3'b101, 3'b010, 1'b0, 1'b1},   // R4 fall
        {3'b101, 3'b011, 1'b1, 1'b1},   // R5 rise
        {3'b101, 3'b011, 1'b0, 1'b1},   // R5 fall
        {3'b101, 3'b101, 1'b1, 1'b1},   // R3 top bit ignored
        {3'b101, 3'b100, 1'b0, 1'b0},   // R6 none
        {3'b100, 3'b011, 1'b1, 1'b0},   // R2 wrong mode
        {3'b101, 3'b110, 1'b0, 1'b1}    // R4 top bit ignored
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_aux;
        exp_aux = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 aux", aux_q, 16'h0);
        chk("R1 flag", {15'b0, req_flag}, 16'h0);
        chk("R1 irq", {15'b0, irq_out}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            mode     = VEC[i][7:5];
            edge_sel = VEC[i][4:2];
            core_tmr = 16'h1000 + 16'(i) * 16'h0111;
            clear_flag();
            pin_in = VEC[i][1];
            repeat (3) @(negedge clk);
            if (VEC[i][0]) exp_aux = core_tmr;
            chk($sformatf("R7 vec%0d aux", i), aux_q, exp_aux);
            chk($sformatf("R2-6 vec%0d flag", i), {15'b0, req_flag}, {15'b0, VEC[i][0]});
        end

        // R8 sticky flag and R9 gating
        mode = 3'b101; edge_sel = 3'b011; core_tmr = 16'hBEEF;
        clear_flag();
        irq_en = 1'b0;
        pin_in = ~pin_in;
        repeat (3) @(negedge clk);
        chk("R8 set", {15'b0, req_flag}, 16'h1);
        chk("R9 irq gated off", {15'b0, irq_out}, 16'h0);
        repeat (5) @(negedge clk);
        chk("R8 sticky", {15'b0, req_flag}, 16'h1);
        irq_en = 1'b1;
        #1;
        chk("R9 irq on", {15'b0, irq_out}, 16'h1);
        clear_flag();
        chk("R8 cleared", {15'b0, req_flag}, 16'h0);
        chk("R9 irq off after clear", {15'b0, irq_out}, 16'h0);

        // R11 software write alone
        aux_wr_en = 1'b1; aux_wr_data = 16'h5A5A;
        @(negedge clk);
        aux_wr_en = 1'b0;
        chk("R11 write", aux_q, 16'h5A5A);

        // R10, R11 clear and write coincide with a trigger
        core_tmr = 16'hC0DE;
        pin_in = ~pin_in;
        repeat (2) @(negedge clk);
        flag_clr = 1'b1; aux_wr_en = 1'b1; aux_wr_data = 16'h1234;
        @(negedge clk);
        flag_clr = 1'b0; aux_wr_en = 1'b0;
        chk("R10 clear loses", {15'b0, req_flag}, 16'h1);
        chk("R11 capture wins", aux_q, 16'hC0DE);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule